// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block converts local-bus accesses that land in a configuration window into type-0 PCI configuration requests. The window offset presented on the window bus is combined with the upper address bits held in a software-programmed map register. The result is split into device, function and register fields. The device number is not a binary field in the address. It comes from the position of the lowest set bit in an eight-bit one-hot select field. That field lies entirely in the address bits supplied by the map register. If the field is empty, the request still goes out with device 0 and the completion carries an error flag.

A small control register bank sits on a separate register bus. It holds the 16-bit map register, returns fixed identification values at a handful of offsets, and flags accesses to anything else. Window accesses run through a four-state machine:

- IDLE: accept the access and capture its decoded fields (transition "accept").
- ISSUE: present the request until the requester takes it ("grant").
- WAIT_RSP: for reads only, wait for the returned data ("data back").
- DONE: assert the window-side ready for one cycle ("retire"), then return to IDLE.

From ISSUE a write goes straight to DONE.

Top module: `pci_cfg_xlate`

## Requirements
- R1: A window access supplies only a 20-bit offset (`win_ofs`). Address bits 31:20 are taken from bits 15:4 of the map register (map bit k lands at address bit k+16).
- R2: The select field is address bits 31:24, which are map bits 15:8. The device number is the index of the lowest set bit in that field: map bit 8 gives device 0 and map bit 15 gives device 7. Map bits 7:0 have no effect on the device number.
- R3: When no bit of the select field is set, the request carries device 0 and the completion of that access raises `win_err`. Otherwise `win_err` is 0.
- R4: `req_func` is offset bits 10:8. `req_reg` is offset bits 7:2 with its two low bits zero. `req_bus` is always 0.
- R5: The map register sits at control offset 0x5E. It is 16 bits wide and resets to 0. A write stores `reg_wdata[15:0]`, and a read returns the stored value zero-extended. Register-bus accesses to other offsets leave it unchanged.
- R6: Fixed read values, with no error: 0x08 returns 4, 0x18 returns 0x11000000, 0x62 returns 0x1100, 0x64 returns 1 (I/O enable), 0x66 returns 0x1D00, and 0x06 returns 0. Writes to these offsets are ignored without error.
- R7: Any other control offset reads as 0, ignores writes, and raises `reg_err` in its response cycle.
- R8: `reg_ready` is high out of reset. The response (`reg_rvalid`, `reg_rdata`, `reg_err`) appears in the cycle after the accepting edge and lasts one cycle.
- R9: Each window access produces exactly one request. While `req_valid` is high and `req_ready` is low, every request field stays stable.
- R10: For a write, `win_ready` is high in the cycle after the request handshake. For a read, `win_ready` is high in the cycle after `rsp_valid`, and `win_rdata` then equals the `rsp_data` sampled with it.
- R11: Data is little-endian and passed unchanged. Byte k of `win_wdata` (bits 8k+7:8k), together with `win_be[k]`, appears on the same lane of `req_wdata`/`req_be`. `rsp_data` reaches `win_rdata` with its lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register bus ready |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Control byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Register response valid |
| reg_rdata | output | 32 | Register read data |
| reg_err | output | 1 | Unimplemented offset flag |
| win_valid | input | 1 | Window access request, held until `win_ready` |
| win_ready | output | 1 | Window access completes |
| win_write | input | 1 | 1 = configuration write |
| win_ofs | input | 20 | Window offset |
| win_wdata | input | 32 | Window write data |
| win_be | input | 4 | Byte enables |
| win_rdata | output | 32 | Configuration read data |
| win_err | output | 1 | No-device flag on completion |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Requester accepts |
| req_write | output | 1 | Request is a write |
| req_bus | output | 8 | Bus number |
| req_dev | output | 5 | Device number |
| req_func | output | 3 | Function number |
| req_reg | output | 8 | Dword-aligned register offset |
| req_wdata | output | 32 | Request write data |
| req_be | output | 4 | Request byte enables |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 32 | Returned read data |

## Verification
Several map patterns with more than one select bit set are used. A scan that picks the highest bit, or that counts from the wrong base, reports the wrong device number. A map with only bits 7:0 set checks the no-device path. A design that looked below bit 8 would report a device there, and one that forgot the flag would complete silently. Requester stalls and delayed read data are applied as well. They expose a design that drops the request early, issues it twice, or retires a read before its data arrives. Writes to read-only and unknown offsets follow, each with a read-back. These catch a map register that is disturbed by a stray decode, and an error flag that fires on the wrong offsets.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_DONE  = 2'd3
    } win_state_e;

    localparam int OFS_STAT  = 'h06;
    localparam int OFS_REV   = 'h08;
    localparam int OFS_DMA1  = 'h18;
    localparam int OFS_MAP   = 'h5E;
    localparam int OFS_MEM1  = 'h62;
    localparam int OFS_L2    = 'h64;
    localparam int OFS_MAP2  = 'h66;

    localparam logic [31:0] VAL_REV  = 32'h0000_0004;
    localparam logic [31:0] VAL_DMA1 = 32'h1100_0000;
    localparam logic [31:0] VAL_MEM1 = 32'h0000_1100;
    localparam logic [31:0] VAL_L2   = 32'h0000_0001;
    localparam logic [31:0] VAL_MAP2 = 32'h0000_1D00;

    localparam int DEV_W  = 5;
    localparam int FUNC_W = 3;
    localparam int REGO_W = 8;
    localparam int BUS_W  = 8;

endpackage

// File: rtl/cfgx_regbank.sv
module cfgx_regbank
    import cfgx_pkg::*;
#(
    parameter int REG_AW = 12,
    parameter int DATA_W = 32,
    parameter int MAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [MAP_W-1:0]  map_q
);

    logic              hit;
    logic [DATA_W-1:0] rd_val;
    logic              map_sel;

    assign map_sel = (addr == REG_AW'(OFS_MAP));

    always_comb begin
        hit    = 1'b1;
        rd_val = '0;
        case (addr)
            REG_AW'(OFS_MAP):  rd_val = DATA_W'(map_q);
            REG_AW'(OFS_STAT): rd_val = '0;
            REG_AW'(OFS_REV):  rd_val = DATA_W'(VAL_REV);
            REG_AW'(OFS_DMA1): rd_val = DATA_W'(VAL_DMA1);
            REG_AW'(OFS_MEM1): rd_val = DATA_W'(VAL_MEM1);
            REG_AW'(OFS_L2):   rd_val = DATA_W'(VAL_L2);
            REG_AW'(OFS_MAP2): rd_val = DATA_W'(VAL_MAP2);
            default:           hit    = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (acc && wr && map_sel) begin
            map_q <= MAP_W'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            err    <= 1'b0;
        end else begin
            rvalid <= acc;
            rdata  <= (acc && !wr) ? rd_val : '0;
            err    <= acc && !hit;
        end
    end

    a_r5_map_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !(wr && map_sel)) |=> $stable(map_q));

    a_r7_err_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rvalid);

    a_r8_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rvalid);

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_OFS_W = 20,
    parameter int MAP_W     = 16,
    parameter int MAP_SHIFT = 16,
    parameter int SEL_LO    = 24,
    parameter int SEL_N     = 8
) (
    input  logic [WIN_OFS_W-1:0] ofs,
    input  logic [MAP_W-1:0]     map_q,
    output logic [DEV_W-1:0]     dev,
    output logic [FUNC_W-1:0]    func,
    output logic [REGO_W-1:0]    rego,
    output logic                 nodev
);

    localparam logic [MAP_W-1:0] MAP_MASK = ~(MAP_W'(4'hF));

    logic [ADDR_W-1:0] full;
    logic [SEL_N-1:0]  sel;
    logic [SEL_N-1:0]  first;
    logic [SEL_N:0]    seen;

    assign full = ADDR_W'(ofs) | (ADDR_W'(map_q & MAP_MASK) << MAP_SHIFT);
    assign sel  = SEL_N'(full >> SEL_LO);
    assign func = FUNC_W'(full >> 8);
    assign rego = REGO_W'(full & ADDR_W'(8'hFC));

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < SEL_N; g++) begin : g_scan
        assign first[g]    = sel[g] & ~seen[g];
        assign seen[g + 1] = seen[g] | sel[g];
    end

    assign nodev = ~seen[SEL_N];

    always_comb begin
        dev = '0;
        for (int i = 0; i < SEL_N; i++) begin
            if (first[i]) dev = dev | DEV_W'(i);
        end
    end

endmodule

// File: rtl/cfgx_win_fsm.sv
module cfgx_win_fsm
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic              win_write,
    input  logic [DATA_W-1:0] win_wdata,
    input  logic [BE_W-1:0]   win_be,
    input  logic [DEV_W-1:0]  dec_dev,
    input  logic [FUNC_W-1:0] dec_func,
    input  logic [REGO_W-1:0] dec_rego,
    input  logic              dec_nodev,
    output logic              win_ready,
    output logic [DATA_W-1:0] win_rdata,
    output logic              win_err,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [DEV_W-1:0]  req_dev,
    output logic [FUNC_W-1:0] req_func,
    output logic [REGO_W-1:0] req_rego,
    output logic [DATA_W-1:0] req_wdata,
    output logic [BE_W-1:0]   req_be,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data
);

    win_state_e state, nxt;

    logic              wr_q;
    logic              nodev_q;
    logic [DEV_W-1:0]  dev_q;
    logic [FUNC_W-1:0] func_q;
    logic [REGO_W-1:0] rego_q;
    logic [DATA_W-1:0] wdata_q;
    logic [BE_W-1:0]   be_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE:  if (win_valid) nxt = W_ISSUE;
            W_ISSUE: if (req_ready) nxt = wr_q ? W_DONE : W_WAIT;
            W_WAIT:  if (rsp_valid) nxt = W_DONE;
            W_DONE:  nxt = W_IDLE;
        endcase
    end

    always_comb begin
        req_valid = 1'b0;
        win_ready = 1'b0;
        unique case (state)
            W_IDLE:  ;
            W_ISSUE: req_valid = 1'b1;
            W_WAIT:  ;
            W_DONE:  win_ready = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            nodev_q <= 1'b0;
            dev_q   <= '0;
            func_q  <= '0;
            rego_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (state == W_IDLE && win_valid) begin
                wr_q    <= win_write;
                nodev_q <= dec_nodev;
                dev_q   <= dec_dev;
                func_q  <= dec_func;
                rego_q  <= dec_rego;
                wdata_q <= win_wdata;
                be_q    <= win_be;
                rdata_q <= '0;
            end
            if (state == W_WAIT && rsp_valid) begin
                rdata_q <= rsp_data;
            end
        end
    end

    assign req_write = wr_q;
    assign req_dev   = dev_q;
    assign req_func  = func_q;
    assign req_rego  = rego_q;
    assign req_wdata = wdata_q;
    assign req_be    = be_q;
    assign win_rdata = rdata_q;
    assign win_err   = win_ready & nodev_q;

    a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_dev) && $stable(req_func)
            && $stable(req_rego) && $stable(req_wdata) && $stable(req_be) && $stable(req_write)));

    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    a_r10_write_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> win_ready);

    a_r10_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_WAIT && rsp_valid) |=> (win_ready && win_rdata == $past(rsp_data)));

    a_r3_err_only_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |-> win_ready);

endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
    import cfgx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_OFS_W = 20,
    parameter int DATA_W    = 32,
    parameter int REG_AW    = 12,
    parameter int MAP_W     = 16,
    parameter int MAP_SHIFT = 16,
    parameter int SEL_LO    = 24,
    parameter int SEL_N     = 8,
    localparam int BE_W     = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    output logic                 reg_ready,
    input  logic                 reg_write,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic                 reg_rvalid,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 reg_err,
    input  logic                 win_valid,
    output logic                 win_ready,
    input  logic                 win_write,
    input  logic [WIN_OFS_W-1:0] win_ofs,
    input  logic [DATA_W-1:0]    win_wdata,
    input  logic [BE_W-1:0]      win_be,
    output logic [DATA_W-1:0]    win_rdata,
    output logic                 win_err,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic                 req_write,
    output logic [BUS_W-1:0]     req_bus,
    output logic [DEV_W-1:0]     req_dev,
    output logic [FUNC_W-1:0]    req_func,
    output logic [REGO_W-1:0]    req_reg,
    output logic [DATA_W-1:0]    req_wdata,
    output logic [BE_W-1:0]      req_be,
    input  logic                 rsp_valid,
    input  logic [DATA_W-1:0]    rsp_data
);

    logic [MAP_W-1:0]  map_q;
    logic [DEV_W-1:0]  dec_dev;
    logic [FUNC_W-1:0] dec_func;
    logic [REGO_W-1:0] dec_rego;
    logic              dec_nodev;

    assign reg_ready = 1'b1;
    assign req_bus   = '0;

    cfgx_regbank #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W),
        .MAP_W  (MAP_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (reg_valid & reg_ready),
        .wr     (reg_write),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rvalid (reg_rvalid),
        .rdata  (reg_rdata),
        .err    (reg_err),
        .map_q  (map_q)
    );

    cfgx_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_OFS_W (WIN_OFS_W),
        .MAP_W     (MAP_W),
        .MAP_SHIFT (MAP_SHIFT),
        .SEL_LO    (SEL_LO),
        .SEL_N     (SEL_N)
    ) u_dec (
        .ofs   (win_ofs),
        .map_q (map_q),
        .dev   (dec_dev),
        .func  (dec_func),
        .rego  (dec_rego),
        .nodev (dec_nodev)
    );

    cfgx_win_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_write (win_write),
        .win_wdata (win_wdata),
        .win_be    (win_be),
        .dec_dev   (dec_dev),
        .dec_func  (dec_func),
        .dec_rego  (dec_rego),
        .dec_nodev (dec_nodev),
        .win_ready (win_ready),
        .win_rdata (win_rdata),
        .win_err   (win_err),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_dev   (req_dev),
        .req_func  (req_func),
        .req_rego  (req_reg),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    a_r4_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bus == '0 && req_reg[1:0] == 2'b00));

endmodule

// File: tb/tb_pci_cfg_xlate.sv
module tb_pci_cfg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_ready, reg_rvalid, reg_err;
    logic [31:0] reg_rdata;
    logic        win_valid = 1'b0, win_write = 1'b0;
    logic [19:0] win_ofs = '0;
    logic [31:0] win_wdata = '0;
    logic [3:0]  win_be = '0;
    logic        win_ready, win_err;
    logic [31:0] win_rdata;
    logic        req_valid, req_write;
    logic        req_ready = 1'b0;
    logic [7:0]  req_bus, req_reg;
    logic [4:0]  req_dev;
    logic [2:0]  req_func;
    logic [31:0] req_wdata;
    logic [3:0]  req_be;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;

    int vectors = 0;
    int miscompares = 0;
    int nreq = 0;
    int map_model = 0;
    bit exp_req = 1'b0;
    bit exp_rdy = 1'b0;
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    pci_cfg_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .reg_err(reg_err),
        .win_valid(win_valid), .win_ready(win_ready), .win_write(win_write),
        .win_ofs(win_ofs), .win_wdata(win_wdata), .win_be(win_be),
        .win_rdata(win_rdata), .win_err(win_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_reg(req_reg),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic chk(bit ok, string tag, longint act, longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (req_valid && req_ready) nreq++;

    // per-clock comparison of handshake outputs against the model's expectation
    always @(negedge clk) begin
        #1;
        if (mon_on) begin
            chk(req_valid == exp_req, "R9 req_valid per cycle", req_valid, exp_req);
            chk(win_ready == exp_rdy, "R10 win_ready per cycle", win_ready, exp_rdy);
        end
    end

    function automatic int m_dev(int m);
        for (int b = 8; b < 16; b++) if (m[b]) return b - 8;
        return 0;
    endfunction

    function automatic bit m_nodev(int m);
        return ((m >> 8) & 255) == 0;
    endfunction

    task automatic reg_do(bit wr, logic [11:0] a, logic [31:0] wd,
                          logic [31:0] er, bit ee, string tag);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        reg_valid = 1'b0;
        if (wr && a == 12'h05E) map_model = int'(wd & 32'hFFFF);
        chk(reg_rvalid == 1'b1, {tag, " R8 rvalid"}, reg_rvalid, 1);
        if (!wr) chk(reg_rdata == er, {tag, " rdata"}, reg_rdata, er);
        chk(reg_err == ee, {tag, " err"}, reg_err, ee);
        @(negedge clk);
        chk(reg_rvalid == 1'b0, {tag, " R8 one-cycle"}, reg_rvalid, 0);
    endtask

    task automatic win_do(bit wr, logic [19:0] ofs, logic [31:0] wd, logic [3:0] be,
                          int hold, int lat, logic [31:0] rd, string tag);
        int n0;
        int edev;
        bit enod;
        n0   = nreq;
        edev = m_dev(map_model);
        enod = m_nodev(map_model);
        @(negedge clk);
        win_valid = 1'b1; win_write = wr; win_ofs = ofs; win_wdata = wd; win_be = be;
        exp_req = 1'b0; exp_rdy = 1'b0;
        @(negedge clk);
        exp_req = 1'b1;
        chk(req_dev == 5'(edev), {tag, " R2 dev"}, req_dev, edev);
        chk(req_func == 3'(ofs >> 8), {tag, " R4 func"}, req_func, (ofs >> 8) & 7);
        chk(req_reg == 8'(ofs & 20'hFC), {tag, " R4 reg"}, req_reg, ofs & 20'hFC);
        chk(req_bus == 8'h00, {tag, " R4 bus"}, req_bus, 0);
        chk(req_write == wr, {tag, " R1 write"}, req_write, wr);
        if (wr) begin
            chk(req_wdata == wd, {tag, " R11 wdata"}, req_wdata, wd);
            chk(req_be == be, {tag, " R11 be"}, req_be, be);
        end
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            exp_req = 1'b1;
            chk(req_dev == 5'(edev), {tag, " R9 hold dev"}, req_dev, edev);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        exp_req = 1'b0;
        if (!wr) begin
            for (int l = 0; l < lat; l++) @(negedge clk);
            rsp_valid = 1'b1; rsp_data = rd;
            @(negedge clk);
            rsp_valid = 1'b0; rsp_data = '0;
            exp_rdy = 1'b1;
            chk(win_rdata == rd, {tag, " R10 R11 rdata"}, win_rdata, rd);
        end else begin
            exp_rdy = 1'b1;
        end
        chk(win_err == enod, {tag, " R3 err"}, win_err, enod);
        win_valid = 1'b0;
        @(negedge clk);
        exp_rdy = 1'b0;
        chk(nreq == n0 + 1, {tag, " R9 one request"}, nreq, n0 + 1);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b0, "reset req_valid", req_valid, 0);
        chk(win_ready == 1'b0, "reset win_ready", win_ready, 0);
        chk(reg_rvalid == 1'b0, "reset R8 rvalid", reg_rvalid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_ready == 1'b1, "R8 ready", reg_ready, 1);
        mon_on = 1'b1;

        reg_do(1'b0, 12'h05E, 0, 32'h0, 1'b0, "R5 map reset");
        win_do(1'b0, 20'h00_3A7, 0, 4'hF, 0, 0, 32'hDEAD_BEEF, "R3 nodev after reset");

        reg_do(1'b1, 12'h05E, 32'hABCD_0100, 0, 1'b0, "R5 map write");
        reg_do(1'b0, 12'h05E, 0, 32'h0000_0100, 1'b0, "R5 map read");
        win_do(1'b0, 20'hF_F5FC, 0, 4'hF, 0, 2, 32'hA1B2_C3D4, "R1 R2 dev0");

        reg_do(1'b1, 12'h05E, 32'h0000_8000, 0, 1'b0, "R5 map");
        win_do(1'b1, 20'h0_0210, 32'h1122_3344, 4'b0110, 2, 0, 0, "R2 dev7 write");

        reg_do(1'b1, 12'h05E, 32'h0000_0C30, 0, 1'b0, "R5 map");
        win_do(1'b0, 20'h0_0704, 0, 4'hF, 1, 3, 32'h0102_0304, "R2 dev2 read");

        reg_do(1'b1, 12'h05E, 32'h0000_00FF, 0, 1'b0, "R5 map");
        win_do(1'b1, 20'h0_0108, 32'hCAFE_F00D, 4'b1001, 0, 0, 0, "R2 R3 low bits only");

        reg_do(1'b1, 12'h05E, 32'h0000_FFF0, 0, 1'b0, "R5 map");
        win_do(1'b0, 20'h8_0343, 0, 4'h1, 0, 0, 32'h5555_AAAA, "R2 all set");

        reg_do(1'b0, 12'h008, 0, 32'h4, 1'b0, "R6 rev");
        reg_do(1'b0, 12'h018, 0, 32'h1100_0000, 1'b0, "R6 dma1");
        reg_do(1'b0, 12'h062, 0, 32'h1100, 1'b0, "R6 mem1");
        reg_do(1'b0, 12'h064, 0, 32'h1, 1'b0, "R6 io enable");
        reg_do(1'b0, 12'h066, 0, 32'h1D00, 1'b0, "R6 map2");
        reg_do(1'b0, 12'h006, 0, 32'h0, 1'b0, "R6 stat");
        reg_do(1'b1, 12'h008, 32'hFFFF_FFFF, 0, 1'b0, "R6 write ro");
        reg_do(1'b0, 12'h008, 0, 32'h4, 1'b0, "R6 rev kept");

        reg_do(1'b0, 12'h010, 0, 32'h0, 1'b1, "R7 bad read");
        reg_do(1'b1, 12'h05C, 32'h0000_1234, 0, 1'b1, "R7 bad write");
        reg_do(1'b1, 12'h05F, 32'h0000_4321, 0, 1'b1, "R7 bad write near map");
        reg_do(1'b0, 12'h05E, 0, 32'h0000_FFF0, 1'b0, "R5 R7 map unchanged");

        reg_do(1'b1, 12'h05E, 32'h0000_2000, 0, 1'b0, "R5 map");
        win_do(1'b0, 20'h0_0628, 0, 4'hF, 0, 0, 32'h8765_4321, "R2 dev5 back to back a");
        win_do(1'b1, 20'h0_0628, 32'h0BAD_CAFE, 4'b1100, 0, 0, 0, "R11 back to back b");

        mon_on = 1'b0;
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule